// File: doc/BRIEF.md
# Length-Prefixed Packet Boot Receiver

This block takes a byte stream from a single input link and places the code it carries into memory. The stream is a run of packets. Each packet is a length byte followed by exactly that many payload bytes. Payload bytes are written to consecutive addresses, and each packet lands directly after the previous one. A length byte of zero closes the run. The block then pulses `done` for one cycle and presents the round's start address on `entry` as the point where execution would begin. Executing that code is outside this block; the `done` pulse stands in for it.

Each loading round starts with an `arm` pulse, and `load_base` supplies the round's start address. The base is taken fresh on every arm and never continues from the previous round. Two packet rounds are allowed per reset. The first loads the loader, and the second, at a base that the loader returned, loads the final code.

Before any packet round, one power-on boot round may be requested by arming with `boot_sel` high. In that round the first byte alone says how many bytes follow. If it is 2 or more, that many bytes are stored from the base and `done` fires as the last byte is written, with no terminator needed. A first byte of 0 or 1 is not a boot image. In that case the block raises `boot_err` and parks until reset.

Top module: `pkt_boot_rx`

## Requirements
- R1: After reset `in_ready`, `mem_we`, `done` and `boot_err` are all 0, and no byte is accepted until an `arm` pulse.
- R2: In a packet round a non-zero length byte L is followed by L payload bytes. Each payload byte is written at the current pointer, which starts at `load_base`, with `mem_we` high in the cycle after the byte's handshake.
- R3: Successive packets of one round land back to back: the first byte of a packet goes to the address after the last byte of the previous packet.
- R4: A length byte of 0 in a packet round causes no write. It gives one cycle of `done` in the cycle after its handshake, with `entry` equal to the round's `load_base`.
- R5: After `done`, and before any arm, `in_ready` stays 0. A held byte is neither lost nor written, and it is accepted as the first byte once the block is re-armed.
- R6: A re-armed round starts writing at its own `load_base` and not at the address after the previous round.
- R7: At most 2 packet rounds (parameter ROUNDS) are accepted per reset. A further `arm` leaves `in_ready` at 0.
- R8: In a boot round (`boot_sel`=1 on the first arm after reset), a first byte N of 2 or more stores the next N bytes from `load_base`. `done` is asserted in the same cycle as the write of the last byte, with `entry`=`load_base`.
- R9: In a boot round a first byte of 0 or 1 causes no write. It sets `boot_err`, which stays 1 with `in_ready` 0 and `arm` ignored until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Incoming link byte |
| in_valid | input | 1 | `in_data` holds a byte |
| in_ready | output | 1 | Byte accepted at this edge when `in_valid` is also high |
| arm | input | 1 | Start a loading round at `load_base` |
| load_base | input | AW | Start address of the round being armed |
| boot_sel | input | 1 | With `arm`, request the power-on boot round |
| mem_we | output | 1 | Write strobe |
| mem_addr | output | AW | Write address |
| mem_data | output | 8 | Write data |
| done | output | 1 | One-cycle end-of-round pulse |
| entry | output | AW | Start address of the current round |
| boot_err | output | 1 | Boot round started with a first byte of 0 or 1 |

## Verification
In a boot round the last payload write and the `done` pulse fall in the same cycle. In packet rounds `done` stands alone after the terminator. The bench pairs each expected end-of-round with a flag saying whether a write must coincide, and checks that flag against `mem_we` on the cycle `done` is seen. A second overlap is tested by holding a byte valid while the block is parked after `done` and arming in the middle of the hold. The scoreboard must show no write during the hold, and the held byte must then act as the new round's first length byte.

// File: rtl/pkt_boot_rx.sv
module pkt_boot_rx #(
  parameter int AW     = 16,
  parameter int ROUNDS = 2,
  localparam int RCW   = $clog2(ROUNDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    in_data,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          arm,
  input  logic [AW-1:0] load_base,
  input  logic          boot_sel,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_data,
  output logic          done,
  output logic [AW-1:0] entry,
  output logic          boot_err
);

  typedef enum logic [2:0] {S_IDLE, S_LEN, S_DATA, S_DONE, S_HALT} st_t;

  st_t           st;
  logic [AW-1:0] ptr, base_q;
  logic [7:0]    cnt;
  logic [RCW-1:0] rounds;
  logic          booted, boot_rd;

  wire parked  = (st == S_IDLE) || (st == S_DONE);
  wire acc     = in_valid && in_ready;
  wire boot_go = arm && (st == S_IDLE) && boot_sel && !booted;
  wire load_go = arm && parked && !boot_go && (rounds < RCW'(ROUNDS));

  assign in_ready = (st == S_LEN) || (st == S_DATA);
  assign entry    = base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ptr      <= '0;
      base_q   <= '0;
      cnt      <= '0;
      rounds   <= '0;
      booted   <= 1'b0;
      boot_rd  <= 1'b0;
      done     <= 1'b0;
      mem_we   <= 1'b0;
      mem_addr <= '0;
      mem_data <= '0;
      boot_err <= 1'b0;
    end else begin
      done   <= 1'b0;
      mem_we <= 1'b0;
      case (st)
        S_IDLE, S_DONE: begin
          if (boot_go || load_go) begin
            st      <= S_LEN;
            ptr     <= load_base;
            base_q  <= load_base;
            boot_rd <= boot_go;
            booted  <= 1'b1;
            if (load_go) rounds <= rounds + 1'b1;
          end
        end
        S_LEN: begin
          if (acc) begin
            if (boot_rd && in_data < 8'd2) begin
              boot_err <= 1'b1;
              st       <= S_HALT;
            end else if (!boot_rd && in_data == 8'd0) begin
              done <= 1'b1;
              st   <= S_DONE;
            end else begin
              cnt <= in_data;
              st  <= S_DATA;
            end
          end
        end
        S_DATA: begin
          if (acc) begin
            mem_we   <= 1'b1;
            mem_addr <= ptr;
            mem_data <= in_data;
            ptr      <= ptr + 1'b1;
            cnt      <= cnt - 1'b1;
            if (cnt == 8'd1) begin
              if (boot_rd) begin
                done <= 1'b1;
                st   <= S_DONE;
              end else begin
                st <= S_LEN;
              end
            end
          end
        end
        default: st <= S_HALT;
      endcase
    end
  end

  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_term_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !boot_rd) |-> !mem_we);

  p_parked_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (parked && $past(parked)) |-> !mem_we);

  p_done_backpress_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);

  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + 1'b1));

  p_rebase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LEN && $past(parked)) |-> (ptr == base_q));

  p_round_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rounds <= RCW'(ROUNDS));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    boot_err |=> (boot_err && !mem_we && !in_ready));

endmodule

// File: tb/pkt_boot_rx_test.sv
module pkt_boot_rx_test;
  localparam int AW = 16;

  logic          clk = 0, rst_n = 0;
  logic [7:0]    in_data = 0;
  logic          in_valid = 0, arm = 0, boot_sel = 0;
  logic [AW-1:0] load_base = 0;
  logic          in_ready, mem_we, done, boot_err;
  logic [AW-1:0] mem_addr, entry;
  logic [7:0]    mem_data;

  int checks = 0, failures = 0;
  bit finished = 0;

  logic [AW+7:0] wq[$];
  logic [AW:0]   dq[$];

  pkt_boot_rx #(.AW(AW), .ROUNDS(2)) uut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .arm(arm), .load_base(load_base), .boot_sel(boot_sel),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
    .done(done), .entry(entry), .boot_err(boot_err));

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: got %h exp %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) begin
        if (wq.size() == 0) chk("R5 unexpected write", {8'h0, mem_addr, mem_data}, 32'hFFFFFFFF);
        else begin
          logic [AW+7:0] e;
          e = wq.pop_front();
          chk("R2/R3/R6 write", {mem_addr, mem_data}, e);
        end
      end
      if (done) begin
        if (dq.size() == 0) chk("R4 unexpected done", {15'h0, entry, 1'b0}, 32'hFFFFFFFF);
        else begin
          logic [AW:0] d;
          d = dq.pop_front();
          chk("R4/R8 entry", entry, d[AW:1]);
          chk("R8 write with done", mem_we, d[0]);
        end
      end
    end
  end

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_data = b; in_valid = 1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 0;
  endtask

  task automatic arm_at(input logic [AW-1:0] b, input logic bs);
    @(negedge clk);
    load_base = b; boot_sel = bs; arm = 1;
    @(negedge clk);
    arm = 0; boot_sel = 0;
  endtask

  task automatic packet(input logic [AW-1:0] at, input int n, input logic [7:0] seed);
    send(8'(n));
    for (int i = 0; i < n; i++) begin
      wq.push_back({at + AW'(i), seed + 8'(i)});
      send(seed + 8'(i));
    end
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic drain;
    repeat (4) @(negedge clk);
    chk("R2 writes drained", wq.size(), 0);
    chk("R4 done drained", dq.size(), 0);
  endtask

  initial begin
    #(5ns * 20000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: got timeout exp finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset;
    @(negedge clk);
    chk("R1 ready", in_ready, 0); chk("R1 we", mem_we, 0);
    chk("R1 done", done, 0);      chk("R1 err", boot_err, 0);
    in_valid = 1; in_data = 8'h05;
    repeat (3) @(negedge clk);
    chk("R1 no accept before arm", in_ready, 0);
    in_valid = 0;

    // R8 boot round: 4 bytes from 0x0040, done with last write
    arm_at(16'h0040, 1);
    send(8'd4);
    for (int i = 0; i < 4; i++) wq.push_back({16'h0040 + 16'(i), 8'h11 * 8'(i + 1)});
    dq.push_back({16'h0040, 1'b1});
    for (int i = 0; i < 4; i++) send(8'h11 * 8'(i + 1));
    drain;

    // R2/R3/R4 first packet round at 0x0100
    arm_at(16'h0100, 0);
    packet(16'h0100, 3, 8'hA0);
    packet(16'h0103, 1, 8'hB0);
    packet(16'h0104, 5, 8'hC0);
    dq.push_back({16'h0100, 1'b0});
    send(8'd0);
    drain;

    // R5 held byte back-pressured, R6 re-armed at a new base
    @(negedge clk);
    in_data = 8'd2; in_valid = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R5 ready low after done", in_ready, 0);
    end
    arm_at(16'h0300, 0);
    chk("R5 ready after re-arm", in_ready, 1);
    @(posedge clk); #1 in_valid = 0;
    wq.push_back({16'h0300, 8'hD1}); send(8'hD1);
    wq.push_back({16'h0301, 8'hD2}); send(8'hD2);
    dq.push_back({16'h0300, 1'b0});
    send(8'd0);
    drain;

    // R7 third packet round refused
    arm_at(16'h0500, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R7 third arm ignored", in_ready, 0);
    end

    // R9 bad boot byte 1, then 0
    for (int v = 0; v < 2; v++) begin
      do_reset;
      @(negedge clk);
      chk("R1 err cleared", boot_err, 0);
      arm_at(16'h0040, 1);
      send(8'(1 - v));
      @(negedge clk);
      chk("R9 err set", boot_err, 1);
      chk("R9 ready low", in_ready, 0);
      arm_at(16'h0080, 0);
      @(negedge clk);
      chk("R9 arm ignored", in_ready, 0);
      chk("R9 err sticky", boot_err, 1);
      drain;
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule